// File: doc/BRIEF.md
# DDR Read Burst Sequencer with Burst Stop

This block models the read side of a double data rate SDRAM device's data path. Commands arrive as active-low chip select, row strobe, column strobe and write enable levels, sampled on each rising clock edge. A read starts a burst whose first data beat appears a programmable CAS latency (2 or 3 clocks) after the command. Two beats leave per clock, one in each clock phase, and the data strobe follows the clock while data is driven. The memory array is not modelled: the block outputs the index of the beat being driven, and the enables of the data and strobe drivers.

A burst stop command cuts an active read short. The data and strobe drivers float exactly CAS-latency clocks after the stop, the same delay a read takes to produce data, so the stop truncates the burst at the matching point. A stop during the write data window is ignored. A stop with no read in progress does nothing. One clock of low strobe, the read preamble, precedes the first beat of a burst that does not follow straight on from another.

Top module: `ddr_rd_burst_ctl`

## Requirements
- R1: After synchronous reset (rst_n low at a rising edge), dq_oe, dqs_oe, dqs_out and beat_idx are all 0.
- R2: Commands are decoded only with cs_n low: ras_n=1, cas_n=0, we_n=1 is a read; ras_n=1, cas_n=0, we_n=0 is a write; ras_n=1, cas_n=1, we_n=0 is a burst stop. With cs_n high nothing is started.
- R3: The first data beat is driven in the clock cycle that begins CL rising edges after the read edge, with CL=3 when cfg_cas_lat is 3 and CL=2 otherwise.
- R4: While data is driven, two beats go out per clock: beat_idx is 2p during the high phase and 2p+1 during the low phase of the p-th cycle of the burst (p from 0), and dqs_out equals the clock level.
- R5: In the cycle before the first beat of a burst, when no data is being driven, dqs_oe is 1, dqs_out is 0 and dq_oe is 0.
- R6: Burst length is 2 for cfg_burst 0 or 1, 4 for 2 and 8 for 3; after the last beat dq_oe and dqs_oe return to 0.
- R7: A burst stop accepted during a read makes dq_oe and dqs_oe 0 from the rising edge CL clocks after the stop edge.
- R8: A burst stop issued with no read active or pending has no effect on the outputs.
- R9: A burst stop on any of the BL/2+1 rising edges following a write edge is ignored.
- R10: A read whose data start coincides with the end of a running burst continues it with no gap and no preamble; a read whose data start falls inside a running burst restarts the beat count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge samples commands |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cfg_cas_lat | input | 2 | CAS latency, 2 or 3 |
| cfg_burst | input | 2 | Burst length code (1:2, 2:4, 3:8) |
| dq_oe | output | 1 | Data driver enable |
| dqs_oe | output | 1 | Strobe driver enable |
| dqs_out | output | 1 | Strobe level when enabled |
| beat_idx | output | 3 | Index of the beat on the data pins |

## Verification
A read edge at cycle k yields a preamble in the window after edge k+CL-1 and beat 0 after edge k+CL; a burst stop at edge s clears the drivers after edge s+CL; a write at edge w blocks stops through edge w+BL/2+1. The bench's model turns each command into due-cycle entries in queues and compares the full output tuple 5 ns after every rising edge (even beat, strobe high) and 5 ns after every falling edge (odd beat, strobe low), so each result is sampled in the phase in which it is due and never at an edge.

// File: rtl/ddr_rd_pkg.sv
package ddr_rd_pkg;
    localparam int CL_MIN   = 2;
    localparam int CL_MAX   = 3;
    localparam int BL_MAX   = 8;
    localparam int PAIR_MAX = BL_MAX / 2;
    localparam int PAIR_W   = $clog2(PAIR_MAX);
    localparam int BEAT_W   = PAIR_W + 1;
    localparam int WR_W     = $clog2(PAIR_MAX + 2);
    localparam int CL_W     = $clog2(CL_MAX);

    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_STOP  = 2'd3
    } ddr_cmd_e;

    typedef struct packed {
        logic [CL_MAX-1:0] rd_pipe;
        logic [CL_MAX-1:0] stop_pipe;
        logic              busy;
        logic [PAIR_W-1:0] pair;
        logic [WR_W-1:0]   wr_left;
    } burst_st_t;
endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
    import ddr_rd_pkg::*;
(
    input  logic     cs_n,
    input  logic     ras_n,
    input  logic     cas_n,
    input  logic     we_n,
    output ddr_cmd_e cmd
);
    always_comb begin
        cmd = CMD_NOP;
        if (!cs_n && ras_n) begin
            case ({cas_n, we_n})
                2'b01:   cmd = CMD_READ;
                2'b00:   cmd = CMD_WRITE;
                2'b10:   cmd = CMD_STOP;
                default: cmd = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/ddr_burst_cfg.sv
module ddr_burst_cfg
    import ddr_rd_pkg::*;
(
    input  logic [1:0]        cfg_burst,
    input  logic [1:0]        cfg_cas_lat,
    output logic [PAIR_W-1:0] pairs_m1,
    output logic [WR_W-1:0]   wr_span,
    output logic [CL_W-1:0]   lat_tap
);
    int pairs;
    int lat;

    always_comb begin
        pairs = (cfg_burst == 2'd0) ? 1 : (1 << (int'(cfg_burst) - 1));
        if (pairs > PAIR_MAX) pairs = PAIR_MAX;
        pairs_m1 = PAIR_W'(pairs - 1);
        wr_span  = WR_W'(pairs + 1);
        lat = int'(cfg_cas_lat);
        if (lat < CL_MIN) lat = CL_MIN;
        if (lat > CL_MAX) lat = CL_MAX;
        lat_tap = CL_W'(lat - 1);
    end
endmodule

// File: rtl/ddr_rd_burst_ctl.sv
module ddr_rd_burst_ctl
    import ddr_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [1:0]        cfg_cas_lat,
    input  logic [1:0]        cfg_burst,
    output logic              dq_oe,
    output logic              dqs_oe,
    output logic              dqs_out,
    output logic [BEAT_W-1:0] beat_idx
);
    ddr_cmd_e          cmd;
    logic [PAIR_W-1:0] pairs_m1;
    logic [WR_W-1:0]   wr_span;
    logic [CL_W-1:0]   lat_tap;
    burst_st_t         st_d, st_q;
    logic              stop_ok, rd_emerge, stop_emerge, preamble;

    ddr_cmd_decode i_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    ddr_burst_cfg i_cfg (
        .cfg_burst   (cfg_burst),
        .cfg_cas_lat (cfg_cas_lat),
        .pairs_m1    (pairs_m1),
        .wr_span     (wr_span),
        .lat_tap     (lat_tap)
    );

    always_comb begin
        st_d        = st_q;
        stop_ok     = (cmd == CMD_STOP) && (st_q.wr_left == '0);
        rd_emerge   = st_q.rd_pipe[lat_tap];
        stop_emerge = st_q.stop_pipe[lat_tap];
        preamble    = rd_emerge && !st_q.busy;

        st_d.rd_pipe   = {st_q.rd_pipe[CL_MAX-2:0], cmd == CMD_READ};
        st_d.stop_pipe = {st_q.stop_pipe[CL_MAX-2:0], stop_ok};

        if (cmd == CMD_WRITE)
            st_d.wr_left = wr_span;
        else if (st_q.wr_left != '0)
            st_d.wr_left = st_q.wr_left - 1'b1;

        if (st_q.busy) begin
            if (st_q.pair == pairs_m1)
                st_d.busy = 1'b0;
            else
                st_d.pair = st_q.pair + 1'b1;
        end
        if (stop_emerge)
            st_d.busy = 1'b0;
        if (rd_emerge) begin
            st_d.busy = 1'b1;
            st_d.pair = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign dq_oe    = st_q.busy;
    assign dqs_oe   = st_q.busy || preamble;
    assign dqs_out  = st_q.busy && clk;
    assign beat_idx = st_q.busy ? {st_q.pair, ~clk} : '0;

    AST_PREAMBLE_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        preamble |=> (st_q.busy && st_q.pair == '0)); // R5

    AST_LAST_PAIR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.pair == pairs_m1 && !rd_emerge) |=> !st_q.busy); // R6

    AST_STOP_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_emerge && !rd_emerge) |=> !dq_oe); // R7

    AST_WRITE_BLOCKS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.wr_left != '0) |=> !st_q.stop_pipe[0]); // R9

    AST_PAIR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.pair != pairs_m1 && !stop_emerge && !rd_emerge)
        |=> (st_q.busy && st_q.pair == PAIR_W'($past(st_q.pair) + 1'b1))); // R4
endmodule

// File: tb/test_ddr_rd_burst_ctl.sv
`timescale 1ns/1ps
module test_ddr_rd_burst_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] cfg_cas_lat = 2'd3;
    logic [1:0] cfg_burst = 2'd2;
    logic       dq_oe, dqs_oe, dqs_out;
    logic [2:0] beat_idx;

    localparam logic [3:0] P_NOP = 4'b0111, P_RD = 4'b0101, P_WR = 4'b0100,
                           P_BST = 4'b0110, P_DES_RD = 4'b1101;

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R1";
    bit    chk_en = 1'b0;

    always #10 clk = ~clk;

    ddr_rd_burst_ctl i_ddr_rd_burst_ctl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cfg_cas_lat(cfg_cas_lat), .cfg_burst(cfg_burst),
        .dq_oe(dq_oe), .dqs_oe(dqs_oe), .dqs_out(dqs_out), .beat_idx(beat_idx)
    );

    // behavioural reference: commands become due-cycle queue entries
    int cyc = 0;
    int rd_due[$];
    int st_due[$];
    bit ra = 1'b0, pre = 1'b0;
    int rp = 0, rpairs = 1, wr_last = -100;

    always @(posedge clk) begin
        int cl, bl;
        cyc++;
        cl = (cfg_cas_lat == 2'd3) ? 3 : 2;
        bl = (cfg_burst == 2'd3) ? 8 : (cfg_burst == 2'd2) ? 4 : 2;
        if (!rst_n) begin
            rd_due.delete(); st_due.delete();
            ra = 0; rp = 0; pre = 0; wr_last = -100;
        end else begin
            if (!cs_n && ras_n && !cas_n && we_n) rd_due.push_back(cyc + cl);
            if (!cs_n && ras_n && !cas_n && !we_n) wr_last = cyc + bl / 2 + 1;
            if (!cs_n && ras_n && cas_n && !we_n && cyc > wr_last) st_due.push_back(cyc + cl);
            if (ra) begin
                rp++;
                if (rp == rpairs) ra = 0;
            end
            if (st_due.size() > 0 && st_due[0] == cyc) begin
                void'(st_due.pop_front());
                ra = 0;
            end
            if (rd_due.size() > 0 && rd_due[0] == cyc) begin
                void'(rd_due.pop_front());
                ra = 1; rp = 0; rpairs = bl / 2;
            end
            pre = !ra && rd_due.size() > 0 && rd_due[0] == cyc + 1;
        end
    end

    task automatic chk(input string phase, input logic [5:0] act, input logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d %s phase: {dq_oe,dqs_oe,dqs_out,beat}=%b expected %b",
                     cur_req, cyc, phase, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #5;
        if (chk_en)
            chk("high", {dq_oe, dqs_oe, dqs_out, beat_idx},
                {ra, ra | pre, ra, ra ? 3'(2 * rp) : 3'd0});
    end

    always @(negedge clk) begin
        #5;
        if (chk_en)
            chk("low", {dq_oe, dqs_oe, dqs_out, beat_idx},
                {ra, ra | pre, 1'b0, ra ? 3'(2 * rp + 1) : 3'd0});
    end

    task automatic put(input logic [3:0] p);
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = p;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put(P_NOP);
    endtask

    task automatic set_cfg(input logic [1:0] cl, input logic [1:0] bc);
        @(negedge clk);
        cfg_cas_lat = cl;
        cfg_burst = bc;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state, checked while reset is held and after release
        @(posedge clk);
        chk_en = 1'b1;
        idle(3);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        cur_req = "R3/R4/R5/R6 CL3 BL4";
        set_cfg(2'd3, 2'd2);
        put(P_RD); idle(8);

        cur_req = "R3/R6 CL2 BL2";
        set_cfg(2'd2, 2'd1);
        put(P_RD); idle(6);

        cur_req = "R6 CL2 BL8";
        set_cfg(2'd2, 2'd3);
        put(P_RD); idle(10);

        cur_req = "R6 code0 is BL2";
        set_cfg(2'd3, 2'd0);
        put(P_RD); idle(6);

        cur_req = "R7 stop CL3 BL8";
        set_cfg(2'd3, 2'd3);
        put(P_RD); put(P_NOP); put(P_BST); idle(10);

        cur_req = "R7 stop CL2 BL8";
        set_cfg(2'd2, 2'd3);
        put(P_RD); idle(2); put(P_BST); idle(10);

        cur_req = "R8 idle stop";
        put(P_BST); idle(5);
        put(P_BST); put(P_RD); idle(10);

        cur_req = "R9 stop in write window";
        set_cfg(2'd3, 2'd3);
        put(P_WR); put(P_RD); put(P_BST); idle(12);
        set_cfg(2'd3, 2'd2);
        put(P_WR); put(P_RD); put(P_NOP); put(P_BST); idle(10);

        cur_req = "R9 stop after write window";
        put(P_WR); put(P_RD); idle(2); put(P_BST); idle(10);

        cur_req = "R10 seamless reads";
        set_cfg(2'd2, 2'd2);
        put(P_RD); put(P_NOP); put(P_RD); idle(10);

        cur_req = "R10 restarting read";
        set_cfg(2'd2, 2'd3);
        put(P_RD); put(P_NOP); put(P_RD); idle(12);

        cur_req = "R2 deselected read";
        put(P_DES_RD); idle(6);

        cur_req = "R1 reset mid-burst";
        put(P_RD); idle(3);
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        @(negedge clk);
        rst_n = 1'b1;
        idle(4);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule